// File: doc/BRIEF.md
# Fan PWM Generator

This block drives a cooling fan with a pulse-width modulated signal and counts the fan's tachometer pulses. Software programs an 8-bit duty value and a 15-bit frequency divisor through a small write/read register port. An internal step counter advances once every F+1 system clocks and wraps after 256 steps, so one PWM period lasts 256 x (F+1) clocks. The logical output is high while the step count is below the duty value.

The output stage can invert polarity, force the output to its inactive level (gate), or switch to open-collector drive. In that mode the data pin stays low and only the enable toggles. A new duty or divisor is held in a shadow register and applied only at the period boundary, so a period is never cut short or stretched mid-way. The tachometer input is synchronised, and its rising edges are counted over one-second windows derived from the system clock rate. The window total is published in a read-only register.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, all readable registers return 0, `fanPwm` is 0 and `fanPwmOe` is 1.
- R2: With no inversion, gating or open-collector drive, `fanPwm` is high for exactly duty x (F+1) clocks of every period. Duty 0 gives a constant low and duty 255 leaves one low step.
- R3: The period between rising edges of `fanPwm` is 256 x (F+1) system clocks, where F is the value in bits 14:0 at offset 0x4.
- R4: A write of duty (offset 0x0 bits 23:16) or F changes nothing in the current period and takes effect from the next period boundary.
- R5: Offset 0x0 bit 3 set inverts the output level, so the high time becomes (256 - duty) x (F+1) clocks per period.
- R6: Offset 0x0 bit 2 set forces the logical PWM level to inactive: constant low, or constant high when inversion is also set.
- R7: Offset 0x0 bit 1 set selects open-collector drive. `fanPwm` stays 0 and `fanPwmOe` is high exactly when the level would be low.
- R8: Offset 0x0 reads back bits 23:16, 3, 2 and 1 as written, and all other bits read 0. Offset 0x4 reads back bits 14:0 only. Writes to offset 0xC are ignored.
- R9: Offset 0xC bits 15:0 return the number of rising edges on `tachIn` in the last completed window of SYS_CLK_HZ clocks. A level held high counts once, and the value is held constant between window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| tachIn | input | 1 | Asynchronous tachometer pulse input |
| fanPwm | output | 1 | PWM data pin |
| fanPwmOe | output | 1 | PWM pin output enable |

## Verification
A prescaler or step counter in the wrong state shows up within one period as a wrong rising-edge spacing or a wrong high-time total over any full-period window. A shadow register loaded at the wrong moment shows up in the period during which the write is made: the high run or period length measured right after the write no longer matches the old setting. A fault in the tachometer path appears only at the next window end, as a wrong value at offset 0xC. A value that drifts inside a window shows as a mismatch on a mid-window read.

// File: rtl/fan_pwm_pkg.sv
`timescale 1ns/1ps
package fan_pwm_pkg;
  typedef struct packed {
    logic step;   // step counter advances this cycle
    logic wrap;   // last step of a period: shadow values load
    logic sec;    // end of a tachometer window
  } fanStrobe_t;

  localparam int CFG_OFS  = 0;
  localparam int FREQ_OFS = 4;
  localparam int TACH_OFS = 12;
  localparam int DUTY_LSB = 16;
  localparam int INV_BIT  = 3;
  localparam int GATE_BIT = 2;
  localparam int OC_BIT   = 1;
endpackage

// File: rtl/fan_pwm_ctl.sv
`timescale 1ns/1ps
module fan_pwm_ctl
  import fan_pwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FREQ_W     = 15,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int SYS_CLK_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  dutyReg,
  output logic              invEn,
  output logic              gateEn,
  output logic              ocEn,
  output logic [FREQ_W-1:0] freqReg,
  output logic [CNT_W-1:0]  cnt,
  output fanStrobe_t        stb
);
  localparam int SEC_W = (SYS_CLK_HZ > 1) ? $clog2(SYS_CLK_HZ) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SYS_CLK_HZ - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [FREQ_W-1:0] freqAct;
  logic [FREQ_W-1:0] preCnt;
  logic [SEC_W-1:0]  secCnt;
  logic              cfgSel;
  logic              freqSel;

  assign cfgSel  = wrEn && (addr == ADDR_W'(CFG_OFS));
  assign freqSel = wrEn && (addr == ADDR_W'(FREQ_OFS));

  wire unusedData = ^{wrData[DATA_W-1:DUTY_LSB+CNT_W], wrData[DUTY_LSB-1:FREQ_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyReg <= '0;
      invEn   <= 1'b0;
      gateEn  <= 1'b0;
      ocEn    <= 1'b0;
      freqReg <= '0;
    end else begin
      if (cfgSel) begin
        dutyReg <= wrData[DUTY_LSB +: CNT_W];
        invEn   <= wrData[INV_BIT];
        gateEn  <= wrData[GATE_BIT];
        ocEn    <= wrData[OC_BIT];
      end
      if (freqSel) freqReg <= wrData[FREQ_W-1:0];
    end
  end

  always_comb begin
    stb.step = (preCnt == freqAct);
    stb.wrap = stb.step && (cnt == CNT_LAST);
    stb.sec  = (secCnt == SEC_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      cnt     <= '0;
      freqAct <= '0;
      secCnt  <= '0;
    end else begin
      preCnt <= stb.step ? '0 : preCnt + 1'b1;
      if (stb.step) cnt <= cnt + 1'b1;
      if (stb.wrap) freqAct <= freqReg;
      secCnt <= stb.sec ? '0 : secCnt + 1'b1;
    end
  end

  assert_prescale_bound_R3: assert property (@(posedge clk) disable iff (rst)
    preCnt <= freqAct);

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
    stb.step |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_freq_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !stb.wrap |=> $stable(freqAct));
endmodule

// File: rtl/fan_pwm_dp.sv
`timescale 1ns/1ps
module fan_pwm_dp
  import fan_pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TACH_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fanStrobe_t        stb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  dutyReg,
  input  logic              invEn,
  input  logic              gateEn,
  input  logic              ocEn,
  input  logic              tachIn,
  output logic              pwmOut,
  output logic              pwmOe,
  output logic [TACH_W-1:0] tachReg
);
  logic [CNT_W-1:0]  dutyAct;
  logic              level;
  logic              tachMeta, tachSync, tachPrev, tachRise;
  logic [TACH_W-1:0] pulseCnt;

  wire unusedStep = stb.step;

  always_ff @(posedge clk) begin
    if (rst) dutyAct <= '0;
    else if (stb.wrap) dutyAct <= dutyReg;
  end

  always_comb begin
    level  = ((cnt < dutyAct) && !gateEn) ^ invEn;
    pwmOut = ocEn ? 1'b0 : level;
    pwmOe  = ocEn ? !level : 1'b1;
  end

  assign tachRise = tachSync && !tachPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      tachMeta <= 1'b0;
      tachSync <= 1'b0;
      tachPrev <= 1'b0;
      pulseCnt <= '0;
      tachReg  <= '0;
    end else begin
      tachMeta <= tachIn;
      tachSync <= tachMeta;
      tachPrev <= tachSync;
      if (stb.sec) begin
        tachReg  <= pulseCnt;
        pulseCnt <= TACH_W'(tachRise);
      end else if (tachRise) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

  assert_duty_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !stb.wrap |=> $stable(dutyAct));

  assert_zero_duty_R2: assert property (@(posedge clk) disable iff (rst)
    (dutyAct == '0 && !invEn && !ocEn) |-> !pwmOut);

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
    (gateEn && !invEn && !ocEn) |-> !pwmOut);

  assert_tach_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !stb.sec |=> $stable(tachReg));
endmodule

// File: rtl/fan_pwm_ctrl.sv
`timescale 1ns/1ps
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FREQ_W     = 15,
  parameter int TACH_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int SYS_CLK_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tachIn,
  output logic              fanPwm,
  output logic              fanPwmOe
);
  fanStrobe_t        stb;
  logic [CNT_W-1:0]  dutyReg, cnt;
  logic              invEn, gateEn, ocEn;
  logic [FREQ_W-1:0] freqReg;
  logic [TACH_W-1:0] tachReg;

  fan_pwm_ctl #(
    .CNT_W(CNT_W), .FREQ_W(FREQ_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SYS_CLK_HZ(SYS_CLK_HZ)
  ) u_ctl (
    .clk(clk), .rst(rst), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .dutyReg(dutyReg), .invEn(invEn), .gateEn(gateEn), .ocEn(ocEn),
    .freqReg(freqReg), .cnt(cnt), .stb(stb)
  );

  fan_pwm_dp #(.CNT_W(CNT_W), .TACH_W(TACH_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cnt(cnt), .dutyReg(dutyReg),
    .invEn(invEn), .gateEn(gateEn), .ocEn(ocEn), .tachIn(tachIn),
    .pwmOut(fanPwm), .pwmOe(fanPwmOe), .tachReg(tachReg)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(CFG_OFS)) begin
      regRdData[DUTY_LSB +: CNT_W] = dutyReg;
      regRdData[INV_BIT]           = invEn;
      regRdData[GATE_BIT]          = gateEn;
      regRdData[OC_BIT]            = ocEn;
    end else if (regAddr == ADDR_W'(FREQ_OFS)) begin
      regRdData[FREQ_W-1:0] = freqReg;
    end else if (regAddr == ADDR_W'(TACH_OFS)) begin
      regRdData[TACH_W-1:0] = tachReg;
    end
  end
endmodule

// File: tb/fan_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module fan_pwm_ctrl_tb;
  localparam int TICK = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        tachIn = 1'b0;
  logic        fanPwm, fanPwmOe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fan_pwm_ctrl #(.SYS_CLK_HZ(TICK)) u_dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tachIn(tachIn),
    .fanPwm(fanPwm), .fanPwmOe(fanPwmOe)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
  endtask

  task automatic countHigh(input int n, input bit useOe, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (useOe ? fanPwmOe : fanPwm) h++;
      @(negedge clk);
    end
  endtask

  task automatic waitRise();
    logic prev;
    prev = fanPwm;
    forever begin
      @(negedge clk);
      if (!prev && fanPwm) break;
      prev = fanPwm;
    end
  endtask

  task automatic measurePeriod(output int p);
    logic prev;
    waitRise();
    p = 0;
    prev = fanPwm;
    forever begin
      @(negedge clk);
      p++;
      if (!prev && fanPwm) break;
      prev = fanPwm;
    end
  endtask

  task automatic waitPhase(input int ph);
    while ((cyc % TICK) != ph) @(negedge clk);
  endtask

  task automatic tachPulse(input int hi);
    tachIn = 1'b1; settle(hi);
    tachIn = 1'b0; settle(3);
  endtask

  task automatic testReset();
    logic [31:0] d;
    checkEq("R1 pwm", fanPwm, 0);
    checkEq("R1 oe", fanPwmOe, 1);
    regRead(4'h0, d); checkEq("R1 cfg", d, 0);
    regRead(4'h4, d); checkEq("R1 freq", d, 0);
    regRead(4'hC, d); checkEq("R1 tach", d, 0);
  endtask

  task automatic testDuty();
    int h;
    regWrite(4'h0, 32'd64 << 16); settle(600);
    countHigh(256, 0, h); checkEq("R2 duty 64", h, 64);
    regWrite(4'h0, 32'd255 << 16); settle(600);
    countHigh(256, 0, h); checkEq("R2 duty 255", h, 255);
    regWrite(4'h0, 32'd0); settle(600);
    countHigh(512, 0, h); checkEq("R2 duty 0", h, 0);
  endtask

  task automatic testPeriod();
    int p, h;
    regWrite(4'h0, 32'd128 << 16);
    regWrite(4'h4, 32'd3); settle(2400);
    measurePeriod(p); checkEq("R3 period F=3", p, 1024);
    countHigh(1024, 0, h); checkEq("R2 high F=3", h, 512);
    regWrite(4'h4, 32'd0); settle(1500);
    measurePeriod(p); checkEq("R3 period F=0", p, 256);
  endtask

  task automatic testShadow();
    int run, p;
    logic prev;
    waitRise();
    regWrite(4'h0, 32'd10 << 16);
    settle(18);
    checkEq("R4 duty held in period", fanPwm, 1);
    waitRise();
    run = 0;
    while (fanPwm) begin run++; @(negedge clk); end
    checkEq("R4 duty next period", run, 10);
    regWrite(4'h0, 32'd128 << 16); settle(600);
    waitRise();
    regWrite(4'h4, 32'd1);
    p = 1; prev = fanPwm;
    forever begin
      @(negedge clk); p++;
      if (!prev && fanPwm) break;
      prev = fanPwm;
    end
    checkEq("R4 freq held in period", p, 256);
    measurePeriod(p); checkEq("R4 freq next period", p, 512);
    regWrite(4'h4, 32'd0); settle(1200);
  endtask

  task automatic testModes();
    int h;
    regWrite(4'h0, (32'd64 << 16) | 32'h8); settle(600);
    countHigh(256, 0, h); checkEq("R5 invert", h, 192);
    regWrite(4'h0, (32'd64 << 16) | 32'h4); settle(600);
    countHigh(256, 0, h); checkEq("R6 gate", h, 0);
    regWrite(4'h0, (32'd64 << 16) | 32'hC); settle(600);
    countHigh(256, 0, h); checkEq("R6 gate invert", h, 256);
    regWrite(4'h0, (32'd64 << 16) | 32'h2); settle(600);
    countHigh(256, 0, h); checkEq("R7 oc pin", h, 0);
    countHigh(256, 1, h); checkEq("R7 oc enable", h, 192);
    regWrite(4'h0, (32'd64 << 16) | 32'hA); settle(600);
    countHigh(256, 1, h); checkEq("R7 oc invert enable", h, 64);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    regWrite(4'h0, 32'hFFFF_FFFF);
    regRead(4'h0, d); checkEq("R8 cfg readback", d, 32'h00FF_000E);
    regWrite(4'h4, 32'hFFFF_8002);
    regRead(4'h4, d); checkEq("R8 freq readback", d, 2);
    regWrite(4'hC, 32'h1234);
    regRead(4'hC, d); checkEq("R8 tach write ignored", d, 0);
    regWrite(4'h0, 32'd0);
    regWrite(4'h4, 32'd0);
  endtask

  task automatic testTach();
    logic [31:0] d;
    waitPhase(200);
    for (int i = 0; i < 7; i++) tachPulse(3);
    tachPulse(50);
    waitPhase(60);
    regRead(4'hC, d); checkEq("R9 window count", d, 8);
    waitPhase(300);
    for (int i = 0; i < 3; i++) tachPulse(4);
    waitPhase(2000);
    regRead(4'hC, d); checkEq("R9 held mid window", d, 8);
    waitPhase(60);
    regRead(4'hC, d); checkEq("R9 next window", d, 3);
    settle(10);
    waitPhase(60);
    regRead(4'hC, d); checkEq("R9 empty window", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    settle(4);
    rst = 1'b0;
    settle(1);
    testReset();
    testDuty();
    testPeriod();
    testShadow();
    testModes();
    testRegs();
    testTach();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule